// File: doc/BRIEF.md
# Vectored Programmable Interrupt Controller

This block gathers requests from eight interrupt lines and presents them to a processor as a single interrupt output. Each line can be configured to trigger on a rising edge or on a high level. A request is latched whether or not its line is masked. The controller then filters the latched requests through a per-line mask and a fixed priority order, with line 0 the most urgent. A request is also held back while any line of equal or higher priority is still in service.

The processor answers with two acknowledge strobes. The first strobe freezes the priority decision and drops the interrupt output. The second strobe marks the chosen line as in service, clears its request, and offers an 8-bit vector on a valid/ready output. The vector combines a programmed 5-bit base with the 3-bit line number. A small write port sets the mask, the trigger modes and the vector base, and issues the non-specific end-of-interrupt command. That command retires the most urgent line still in service.

The vector port follows valid/ready rules. Once `vec_valid_o` rises, `vec_o` holds steady until a cycle in which `vec_ready_i` is high. While a vector is waiting, further acknowledge strobes are ignored. The interrupt output is only evaluated again after the vector has been accepted.

Top module: `vpic_ctrl`

## Requirements
- R1: After reset, `intr_o` and `vec_valid_o` are 0, no request or in-service state is held, all eight lines are masked, all lines are in edge mode and the vector base is 0.
- R2: In edge mode (mode bit 0), a line sets its request on a 0-to-1 transition. A line that stays high does not request again after it has been acknowledged.
- R3: In level mode (mode bit 1), a line sets its request in every cycle it is high. A line still high after its acknowledge requests again. A request stays latched after the line drops, until it is acknowledged.
- R4: A request is latched even while its line is masked, but it never drives `intr_o`. Once the line is unmasked, the latched request asserts `intr_o`.
- R5: Priority is fixed and line 0 is the highest. When several lines are pending, the acknowledge returns the lowest-numbered eligible line.
- R6: While a line is in service, requests on that line and on all higher-numbered lines do not assert `intr_o`. A request on a lower-numbered line still does.
- R7: The first acknowledge strobe drops `intr_o` and freezes the winning line. Requests that arrive before the second strobe do not change the returned vector.
- R8: The vector is {base[7:3], line[2:0]}. It appears with `vec_valid_o` one cycle after the second strobe. Valid and data hold until accepted with `vec_ready_i`, and strobes are ignored while the vector waits.
- R9: The second strobe sets the winning line's in-service bit and clears its request bit.
- R10: Writing command data with bit 5 set clears only the lowest-numbered in-service bit that is set.
- R11: If no line is eligible at the first strobe, the vector carries line number 7 and no in-service bit is set.
- R12: Write addresses are: 0 mask (bit n = 1 masks line n), 1 trigger mode (bit n = 1 selects level for line n), 2 vector base (only data bits 7:3 are kept), 3 command (bit 5 = end of interrupt).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | 8 | Interrupt request lines, synchronous to clk |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | 8 | Register write data |
| inta_i | input | 1 | Acknowledge strobe, one cycle per pulse |
| intr_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 8 | Interrupt vector |
| vec_valid_o | output | 1 | Vector valid |
| vec_ready_i | input | 1 | Vector accepted by the consumer |

## Verification
On every cycle, the assertions check the following:
- edge and level triggers latch into the request bits;
- `intr_o` is never driven by masked requests;
- the interrupt output drops after a first strobe;
- each acknowledge sets its in-service bit;
- an end-of-interrupt retires exactly one in-service bit;
- a waiting vector stays stable.

Only the bench scenarios can show the following:
- the priority order across pending lines;
- the nesting of in-service lines against new requests;
- the freeze of the winner between the two strobes;
- the level-mode re-request;
- the spurious vector;
- the discarded low base bits.

// File: rtl/vpic_pkg.sv
package vpic_pkg;

  typedef enum logic [1:0] {
    ACK_IDLE   = 2'd0,
    ACK_FROZEN = 2'd1,
    ACK_VECTOR = 2'd2
  } ack_state_e;

  localparam logic [1:0] ADDR_MASK = 2'd0;
  localparam logic [1:0] ADDR_MODE = 2'd1;
  localparam logic [1:0] ADDR_BASE = 2'd2;
  localparam logic [1:0] ADDR_CMD  = 2'd3;
  localparam int         CMD_EOI_BIT = 5;

endpackage

// File: rtl/vpic_req_latch.sv
module vpic_req_latch #(
  parameter int NUM_LINES = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_i,
  input  logic [NUM_LINES-1:0] level_i,
  input  logic [NUM_LINES-1:0] clr_i,
  output logic [NUM_LINES-1:0] irr_o
);

  logic [NUM_LINES-1:0] prev_q;
  logic [NUM_LINES-1:0] irr_q;
  logic [NUM_LINES-1:0] rise;
  logic [NUM_LINES-1:0] set_v;

  assign rise = irq_i & ~prev_q;

  genvar g;
  generate
    for (g = 0; g < NUM_LINES; g++) begin : g_line
      assign set_v[g] = level_i[g] ? irq_i[g] : rise[g];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      irr_q  <= '0;
    end else begin
      prev_q <= irq_i;
      irr_q  <= (irr_q & ~clr_i) | set_v;
    end
  end

  assign irr_o = irr_q;

  // R2: an edge-mode rising transition leaves the request bit set
  a_r2_edge_latches: assert property (@(posedge clk) disable iff (!rst_n)
    ((rise & ~level_i) != '0) |=>
      ((irr_o & $past(rise & ~level_i)) == $past(rise & ~level_i)));

  // R3: a level-mode high line leaves the request bit set
  a_r3_level_latches: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_i & level_i) != '0) |=>
      ((irr_o & $past(irq_i & level_i)) == $past(irq_i & level_i)));

endmodule

// File: rtl/vpic_prio.sv
module vpic_prio #(
  parameter int NUM_LINES = 8,
  parameter int ID_W      = $clog2(NUM_LINES)
) (
  input  logic [NUM_LINES-1:0] irr_i,
  input  logic [NUM_LINES-1:0] imr_i,
  input  logic [NUM_LINES-1:0] isr_i,
  output logic                 found_o,
  output logic [ID_W-1:0]      id_o
);

  always_comb begin
    logic blocked;
    blocked = 1'b0;
    found_o = 1'b0;
    id_o    = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      blocked = blocked | isr_i[i];
      if (!found_o && !blocked && irr_i[i] && !imr_i[i]) begin
        found_o = 1'b1;
        id_o    = ID_W'(i);
      end
    end
  end

  // R4: a granted line is always a pending, unmasked one
  always_comb begin
    if (found_o) begin
      a_r4_grant_unmasked: assert (irr_i[id_o] && !imr_i[id_o]);
    end
  end

endmodule

// File: rtl/vpic_isr.sv
module vpic_isr #(
  parameter int NUM_LINES = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] ack_set_i,
  input  logic                 eoi_i,
  output logic [NUM_LINES-1:0] isr_o
);

  logic [NUM_LINES-1:0] isr_q;
  logic [NUM_LINES-1:0] lowest;
  logic [NUM_LINES-1:0] retire;

  assign lowest = isr_q & (~isr_q + NUM_LINES'(1));
  assign retire = eoi_i ? lowest : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) isr_q <= '0;
    else        isr_q <= (isr_q & ~retire) | ack_set_i;
  end

  assign isr_o = isr_q;

  // R9: an acknowledge leaves its in-service bit set
  a_r9_ack_sets_isr: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_set_i != '0) |=> ((isr_o & $past(ack_set_i)) == $past(ack_set_i)));

  // R10: an end of interrupt retires exactly one in-service bit
  a_r10_eoi_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_i && isr_o != '0 && ack_set_i == '0) |=>
      ($countones(isr_o) + 1 == $countones($past(isr_o))));

endmodule

// File: rtl/vpic_ack_fsm.sv
module vpic_ack_fsm
  import vpic_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int VEC_W     = 8,
  parameter int ID_W      = $clog2(NUM_LINES),
  parameter int BASE_W    = VEC_W - ID_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 inta_i,
  input  logic                 found_i,
  input  logic [ID_W-1:0]      id_i,
  input  logic [BASE_W-1:0]    base_i,
  input  logic                 vec_ready_i,
  output logic                 busy_o,
  output logic [NUM_LINES-1:0] ack_set_o,
  output logic [VEC_W-1:0]     vec_o,
  output logic                 vec_valid_o
);

  ack_state_e         state_q;
  logic               hold_found_q;
  logic [ID_W-1:0]    hold_id_q;
  logic [VEC_W-1:0]   vec_q;
  logic               second_pulse;

  assign second_pulse = (state_q == ACK_FROZEN) && inta_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ACK_IDLE;
      hold_found_q <= 1'b0;
      hold_id_q    <= '0;
      vec_q        <= '0;
    end else begin
      unique case (state_q)
        ACK_IDLE: if (inta_i) begin
          state_q      <= ACK_FROZEN;
          hold_found_q <= found_i;
          hold_id_q    <= found_i ? id_i : '1;
        end
        ACK_FROZEN: if (inta_i) begin
          state_q <= ACK_VECTOR;
          vec_q   <= {base_i, hold_id_q};
        end
        ACK_VECTOR: if (vec_ready_i) state_q <= ACK_IDLE;
        default: state_q <= ACK_IDLE;
      endcase
    end
  end

  assign ack_set_o   = (second_pulse && hold_found_q) ?
                       (NUM_LINES'(1) << hold_id_q) : '0;
  assign busy_o      = (state_q != ACK_IDLE);
  assign vec_valid_o = (state_q == ACK_VECTOR);
  assign vec_o       = vec_q;

  // R8: a waiting vector keeps valid and data until accepted
  a_r8_vec_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid_o && !vec_ready_i) |=> (vec_valid_o && $stable(vec_o)));

  // R9: at most one line is acknowledged at a time
  a_r9_one_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_set_o));

endmodule

// File: rtl/vpic_ctrl.sv
module vpic_ctrl
  import vpic_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int VEC_W     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_i,
  input  logic                 wr_en_i,
  input  logic [1:0]           wr_addr_i,
  input  logic [VEC_W-1:0]     wr_data_i,
  input  logic                 inta_i,
  output logic                 intr_o,
  output logic [VEC_W-1:0]     vec_o,
  output logic                 vec_valid_o,
  input  logic                 vec_ready_i
);

  localparam int ID_W   = $clog2(NUM_LINES);
  localparam int BASE_W = VEC_W - ID_W;

  logic [NUM_LINES-1:0] imr_q;
  logic [NUM_LINES-1:0] lvl_q;
  logic [BASE_W-1:0]    base_q;
  logic [NUM_LINES-1:0] irr;
  logic [NUM_LINES-1:0] isr;
  logic [NUM_LINES-1:0] ack_set;
  logic                 found;
  logic [ID_W-1:0]      win_id;
  logic                 busy;
  logic                 eoi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imr_q  <= '1;
      lvl_q  <= '0;
      base_q <= '0;
    end else if (wr_en_i) begin
      unique case (wr_addr_i)
        ADDR_MASK: imr_q  <= wr_data_i[NUM_LINES-1:0];
        ADDR_MODE: lvl_q  <= wr_data_i[NUM_LINES-1:0];
        ADDR_BASE: base_q <= wr_data_i[VEC_W-1:ID_W];
        default: ;
      endcase
    end
  end

  assign eoi = wr_en_i && (wr_addr_i == ADDR_CMD) && wr_data_i[CMD_EOI_BIT];

  vpic_req_latch #(.NUM_LINES(NUM_LINES)) u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq_i   (irq_i),
    .level_i (lvl_q),
    .clr_i   (ack_set),
    .irr_o   (irr)
  );

  vpic_prio #(.NUM_LINES(NUM_LINES), .ID_W(ID_W)) u_prio (
    .irr_i   (irr),
    .imr_i   (imr_q),
    .isr_i   (isr),
    .found_o (found),
    .id_o    (win_id)
  );

  vpic_isr #(.NUM_LINES(NUM_LINES)) u_isr (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack_set_i (ack_set),
    .eoi_i     (eoi),
    .isr_o     (isr)
  );

  vpic_ack_fsm #(
    .NUM_LINES(NUM_LINES), .VEC_W(VEC_W), .ID_W(ID_W), .BASE_W(BASE_W)
  ) u_ack (
    .clk         (clk),
    .rst_n       (rst_n),
    .inta_i      (inta_i),
    .found_i     (found),
    .id_i        (win_id),
    .base_i      (base_q),
    .vec_ready_i (vec_ready_i),
    .busy_o      (busy),
    .ack_set_o   (ack_set),
    .vec_o       (vec_o),
    .vec_valid_o (vec_valid_o)
  );

  assign intr_o = found && !busy;

  // R4: the interrupt output is only driven by unmasked pending requests
  a_r4_masked_no_intr: assert property (@(posedge clk) disable iff (!rst_n)
    intr_o |-> ((irr & ~imr_q) != '0));

  // R7: a first strobe while interrupting drops the output
  a_r7_intr_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (inta_i && intr_o) |=> !intr_o);

endmodule

// File: tb/test_vpic_ctrl.sv
module test_vpic_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq = '0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       inta = 1'b0;
  logic       intr;
  logic [7:0] vec;
  logic       vec_valid;
  logic       vec_ready = 1'b0;

  int checks = 0;
  int fails  = 0;
  logic [7:0] base = 8'h00;

  always #2 clk = ~clk;

  vpic_ctrl i_vpic_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_i(irq),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .inta_i(inta), .intr_o(intr), .vec_o(vec),
    .vec_valid_o(vec_valid), .vec_ready_i(vec_ready)
  );

  function automatic logic [7:0] exp_vec(input logic [7:0] b, input int line);
    return {b[7:3], 3'(line)};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic eoi();
    write_reg(2'd3, 8'h20);
  endtask

  task automatic set_irq(input logic [7:0] v);
    @(negedge clk);
    irq = v;
    @(negedge clk);
  endtask

  task automatic pulse_inta();
    @(negedge clk);
    inta = 1'b1;
    @(negedge clk);
    inta = 1'b0;
  endtask

  task automatic do_ack(input string req, input logic [7:0] exp);
    pulse_inta();
    check("R7 intr low after first strobe", {7'd0, intr}, 8'd0);
    pulse_inta();
    check({req, " valid"}, {7'd0, vec_valid}, 8'd1);
    check({req, " vector"}, vec, exp);
    vec_ready = 1'b1;
    @(negedge clk);
    vec_ready = 1'b0;
    check({req, " valid drops"}, {7'd0, vec_valid}, 8'd0);
  endtask

  task automatic t_reset();
    check("R1 intr", {7'd0, intr}, 8'd0);
    check("R1 valid", {7'd0, vec_valid}, 8'd0);
    set_irq(8'h01);
    check("R1 all masked", {7'd0, intr}, 8'd0);
    write_reg(2'd0, 8'h00);
    check("R4 latched while masked", {7'd0, intr}, 8'd1);
    do_ack("R1 base zero", exp_vec(base, 0));
    eoi();
    set_irq(8'h00);
    check("R1 idle", {7'd0, intr}, 8'd0);
  endtask

  task automatic t_mask();
    write_reg(2'd0, 8'h08);
    set_irq(8'h08);
    set_irq(8'h00);
    check("R4 masked no intr", {7'd0, intr}, 8'd0);
    write_reg(2'd0, 8'h00);
    check("R12 mask write", {7'd0, intr}, 8'd1);
    do_ack("R4 unmasked", exp_vec(base, 3));
    eoi();
    check("R4 done", {7'd0, intr}, 8'd0);
  endtask

  task automatic t_priority();
    base = 8'h40;
    write_reg(2'd2, base);
    set_irq(8'h24);
    do_ack("R5 lowest wins", exp_vec(base, 2));
    check("R6 lower blocked", {7'd0, intr}, 8'd0);
    eoi();
    check("R10 eoi reopens", {7'd0, intr}, 8'd1);
    do_ack("R5 next line", exp_vec(base, 5));
    eoi();
    set_irq(8'h00);
    check("R9 requests cleared", {7'd0, intr}, 8'd0);
  endtask

  task automatic t_nesting();
    set_irq(8'h10);
    do_ack("R6 line4", exp_vec(base, 4));
    set_irq(8'h50);
    check("R6 lower blocked by 4", {7'd0, intr}, 8'd0);
    set_irq(8'h52);
    check("R6 higher interrupts", {7'd0, intr}, 8'd1);
    do_ack("R6 line1", exp_vec(base, 1));
    eoi();
    check("R10 only line1 retired", {7'd0, intr}, 8'd0);
    eoi();
    check("R10 line4 retired", {7'd0, intr}, 8'd1);
    do_ack("R6 line6", exp_vec(base, 6));
    eoi();
    set_irq(8'h00);
    check("R6 done", {7'd0, intr}, 8'd0);
  endtask

  task automatic t_freeze();
    set_irq(8'h20);
    pulse_inta();
    check("R7 intr low", {7'd0, intr}, 8'd0);
    set_irq(8'h21);
    check("R7 intr stays low", {7'd0, intr}, 8'd0);
    pulse_inta();
    check("R7 frozen vector", vec, exp_vec(base, 5));
    vec_ready = 1'b1;
    @(negedge clk);
    vec_ready = 1'b0;
    check("R7 re-evaluated", {7'd0, intr}, 8'd1);
    do_ack("R7 line0", exp_vec(base, 0));
    eoi();
    eoi();
    set_irq(8'h00);
    check("R7 done", {7'd0, intr}, 8'd0);
  endtask

  task automatic t_backpressure();
    set_irq(8'h04);
    pulse_inta();
    pulse_inta();
    check("R8 valid", {7'd0, vec_valid}, 8'd1);
    set_irq(8'h06);
    repeat (3) @(negedge clk);
    pulse_inta();
    pulse_inta();
    check("R8 held valid", {7'd0, vec_valid}, 8'd1);
    check("R8 held vector", vec, exp_vec(base, 2));
    check("R8 intr low while waiting", {7'd0, intr}, 8'd0);
    vec_ready = 1'b1;
    @(negedge clk);
    vec_ready = 1'b0;
    check("R8 accepted", {7'd0, vec_valid}, 8'd1 ^ 8'd1);
    check("R8 line1 pending", {7'd0, intr}, 8'd1);
    do_ack("R8 line1", exp_vec(base, 1));
    eoi();
    eoi();
    set_irq(8'h00);
    check("R8 done", {7'd0, intr}, 8'd0);
  endtask

  task automatic t_edge_hold();
    set_irq(8'h04);
    do_ack("R2 edge", exp_vec(base, 2));
    eoi();
    check("R2 held high no re-request", {7'd0, intr}, 8'd0);
    set_irq(8'h00);
  endtask

  task automatic t_level();
    write_reg(2'd1, 8'h08);
    set_irq(8'h08);
    check("R3 level request", {7'd0, intr}, 8'd1);
    do_ack("R3 level", exp_vec(base, 3));
    check("R6 in service blocks", {7'd0, intr}, 8'd0);
    eoi();
    check("R3 re-request while high", {7'd0, intr}, 8'd1);
    set_irq(8'h00);
    check("R3 latched after drop", {7'd0, intr}, 8'd1);
    do_ack("R3 level again", exp_vec(base, 3));
    eoi();
    check("R3 cleared", {7'd0, intr}, 8'd0);
    write_reg(2'd1, 8'h00);
  endtask

  task automatic t_spurious();
    check("R11 idle", {7'd0, intr}, 8'd0);
    do_ack("R11 spurious", exp_vec(base, 7));
    set_irq(8'h80);
    check("R11 no isr set", {7'd0, intr}, 8'd1);
    do_ack("R11 real line7", exp_vec(base, 7));
    eoi();
    set_irq(8'h00);
  endtask

  task automatic t_base_bits();
    write_reg(2'd2, 8'hA7);
    base = 8'hA0;
    set_irq(8'h02);
    do_ack("R12 base low bits dropped", 8'hA1);
    eoi();
    set_irq(8'h00);
    check("R12 done", {7'd0, intr}, 8'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mask();
    t_priority();
    t_nesting();
    t_freeze();
    t_backpressure();
    t_edge_hold();
    t_level();
    t_spurious();
    t_base_bits();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule